// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block is an on-chip scratchpad of 32-bit words spread across word-interleaved banks. Each bank can service one word per clock. A group of lane requests is presented at once, one request per lane. Each lane carries a valid bit, a word address, a write flag and write data. The block works out which lanes collide on a bank and splits the group into serialized passes. The number of passes equals the largest count of distinct word addresses that any single bank receives.

Lanes that name the same word are merged into a single bank access. A group in which every lane reads one common word therefore finishes in a single pass as a broadcast. Read results are registered per lane. A one-cycle done pulse marks the cycle from which every lane's read data can be used. A ready output is low for as long as a group is being serviced.

The block is meant to sit behind a lane-parallel execution unit. That unit offers a group when ready is high and collects the results on done. Separate groups never interact beyond the memory contents they leave behind.

Top module: `scr_arbiter`

## Requirements
- R1: A word address selects bank = address mod BANKS (the low log2(BANKS) bits) and row = address / BANKS (the remaining upper bits). A word written at an address is returned by a later read of that same address.
- R2: A group whose valid lanes all fall in different banks takes exactly one pass. With P passes, a group accepted on clock edge A raises done in the cycle that follows edge A+P.
- R3: A group in which every valid lane reads one identical address takes one pass, and every lane receives that word.
- R4: The pass count equals the largest number of distinct addresses among the valid lanes that map to one bank, with a minimum of 1. Lanes naming the same address count once. A stride of 1 or any odd stride gives 1 pass, stride 2 gives 2, stride 8 gives 8 and stride 16 gives 16.
- R5: When several valid lanes of one group write the same address, the data of the highest-numbered of those lanes is what remains stored.
- R6: Every read in a group returns the word as it was before the group began, even when another lane of the same group writes that word.
- R7: A group is accepted on a clock edge where grp_start and ready are both high. Ready is low from that edge until the edge that raises done. A grp_start while ready is low is ignored and stores nothing.
- R8: Done is high for exactly one cycle per group, and ready is high in that cycle. lane_rdata of read lanes holds its value until a later group captures new data.
- R9: Lanes with lane_valid low neither write nor count toward the pass count. A group with no valid lane completes in one pass.
- R10: After reset, ready is 1, done is 0, every lane_rdata is 0 and every stored word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| grp_start | input | 1 | Offers a request group; taken when ready is high |
| ready | output | 1 | High when a new group can be accepted |
| lane_valid | input | LANES | Per-lane request valid |
| lane_we | input | LANES | Per-lane write flag (1 write, 0 read) |
| lane_addr | input | LANES x ADDR_W | Per-lane word address |
| lane_wdata | input | LANES x WORD_W | Per-lane write data |
| lane_rdata | output | LANES x WORD_W | Per-lane registered read data |
| done | output | 1 | One-cycle pulse when the whole group is finished |

## Verification
Suppose the per-bank leader choice or the pending mask goes wrong. The result shows up as a wrong cycle count between acceptance and done, so every group's length is compared with the count computed from its addresses. Suppose instead a lane is dropped, served twice or served with the wrong row. Then its read data is wrong, or a stored word is corrupted and shows up on a later read-back. A wrong write-merge order shows up as a wrong value the next time that address is read. Most faults therefore appear either within the same group or on the next read of the affected word.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int DEF_LANES  = 16;
    localparam int DEF_BANKS  = 16;
    localparam int DEF_ROWS   = 16;
    localparam int DEF_WORD_W = 32;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } scr_state_e;

endpackage

// File: rtl/scr_bank.sv
module scr_bank #(
    parameter int ROWS   = 16,
    parameter int WORD_W = 32,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  row,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] store [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) begin
                store[r] <= '0;
            end
        end else if (wr_en) begin
            store[row] <= wdata;
        end
    end

    assign rdata = store[row];

endmodule

// File: rtl/scr_pass_sel.sv
module scr_pass_sel #(
    parameter int LANES  = 16,
    parameter int BANKS  = 16,
    parameter int ROWS   = 16,
    parameter int WORD_W = 32,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = BANK_W + ROW_W
) (
    input  logic [LANES-1:0]             pending,
    input  logic [LANES-1:0]             req_we,
    input  logic [LANES-1:0][ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0][WORD_W-1:0] req_wdata,
    output logic [LANES-1:0]             served,
    output logic [BANKS-1:0][ROW_W-1:0]  bank_row,
    output logic [BANKS-1:0]             bank_we,
    output logic [BANKS-1:0][WORD_W-1:0] bank_wdata
);

    logic [BANKS-1:0] bank_used;

    // Lowest-numbered pending lane of each bank picks the row served this pass.
    always_comb begin
        bank_used = '0;
        bank_row  = '0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (pending[l]) begin
                bank_used[req_addr[l][BANK_W-1:0]] = 1'b1;
                bank_row[req_addr[l][BANK_W-1:0]]  = req_addr[l][ADDR_W-1:BANK_W];
            end
        end
    end

    // Every pending lane naming the chosen row of its bank is merged in.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            served[l] = pending[l]
                     && bank_used[req_addr[l][BANK_W-1:0]]
                     && (bank_row[req_addr[l][BANK_W-1:0]] == req_addr[l][ADDR_W-1:BANK_W]);
        end
    end

    // Ascending scan: the highest served writer of a bank supplies the data.
    always_comb begin
        bank_we    = '0;
        bank_wdata = '0;
        for (int l = 0; l < LANES; l++) begin
            if (served[l] && req_we[l]) begin
                bank_we[req_addr[l][BANK_W-1:0]]    = 1'b1;
                bank_wdata[req_addr[l][BANK_W-1:0]] = req_wdata[l];
            end
        end
    end

endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
    import scr_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grp_start,
    input  logic [LANES-1:0] lane_valid,
    input  logic [LANES-1:0] served,
    output logic             accept,
    output logic             busy,
    output logic [LANES-1:0] pending,
    output logic             done
);

    scr_state_e       state;
    logic [LANES-1:0] remain;

    assign busy   = (state == ST_BUSY);
    assign accept = grp_start && !busy;
    assign remain = pending & ~served;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pending <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (grp_start) begin
                        pending <= lane_valid;
                        state   <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    pending <= remain;
                    if (remain == '0) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/scr_arbiter.sv
module scr_arbiter
    import scr_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int BANKS  = DEF_BANKS,
    parameter int ROWS   = DEF_ROWS,
    parameter int WORD_W = DEF_WORD_W,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = BANK_W + ROW_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         grp_start,
    output logic                         ready,
    input  logic [LANES-1:0]             lane_valid,
    input  logic [LANES-1:0]             lane_we,
    input  logic [LANES-1:0][ADDR_W-1:0] lane_addr,
    input  logic [LANES-1:0][WORD_W-1:0] lane_wdata,
    output logic [LANES-1:0][WORD_W-1:0] lane_rdata,
    output logic                         done
);

    logic                         accept;
    logic                         busy;
    logic [LANES-1:0]             pending;
    logic [LANES-1:0]             served;
    logic [LANES-1:0]             req_we;
    logic [LANES-1:0][ADDR_W-1:0] req_addr;
    logic [LANES-1:0][WORD_W-1:0] req_wdata;
    logic [BANKS-1:0][ROW_W-1:0]  bank_row;
    logic [BANKS-1:0]             bank_we;
    logic [BANKS-1:0][WORD_W-1:0] bank_wdata;
    logic [BANKS-1:0][WORD_W-1:0] bank_rd;

    assign ready = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_we    <= '0;
            req_addr  <= '0;
            req_wdata <= '0;
        end else if (accept) begin
            req_we    <= lane_we;
            req_addr  <= lane_addr;
            req_wdata <= lane_wdata;
        end
    end

    scr_ctrl #(.LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .grp_start  (grp_start),
        .lane_valid (lane_valid),
        .served     (served),
        .accept     (accept),
        .busy       (busy),
        .pending    (pending),
        .done       (done)
    );

    scr_pass_sel #(
        .LANES  (LANES),
        .BANKS  (BANKS),
        .ROWS   (ROWS),
        .WORD_W (WORD_W)
    ) u_sel (
        .pending    (pending),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .served     (served),
        .bank_row   (bank_row),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        scr_bank #(.ROWS(ROWS), .WORD_W(WORD_W)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .wr_en (busy && bank_we[b]),
            .row   (bank_row[b]),
            .wdata (bank_wdata[b]),
            .rdata (bank_rd[b])
        );
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_rdata[l] <= '0;
            end else if (busy && served[l] && !req_we[l]) begin
                lane_rdata[l] <= bank_rd[req_addr[l][BANK_W-1:0]];
            end
        end
    end

endmodule

// File: rtl/scr_arbiter_chk.sv
module scr_arbiter_chk #(
    parameter int LANES = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             grp_start,
    input logic             ready,
    input logic             done,
    input logic [LANES-1:0] pending,
    input logic [LANES-1:0] served
);

    int unsigned busy_cycles;

    always_ff @(posedge clk) begin
        if (rst || ready) begin
            busy_cycles <= 0;
        end else begin
            busy_cycles <= busy_cycles + 1;
        end
    end

    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (grp_start && ready) |=> !ready);

    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(!ready));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_ready: assert property (@(posedge clk) disable iff (rst)
        done |-> ready);

    a_r4_pass_progress: assert property (@(posedge clk) disable iff (rst)
        (!ready && pending != '0) |-> (served != '0));

    a_r4_pass_bound: assert property (@(posedge clk) disable iff (rst)
        busy_cycles <= LANES);

endmodule

bind scr_arbiter scr_arbiter_chk #(.LANES(LANES)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .grp_start (grp_start),
    .ready     (ready),
    .done      (done),
    .pending   (pending),
    .served    (served)
);

// File: tb/test_scr_arbiter.sv
module test_scr_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int NB = 16;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NWORDS = 256;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     grp_start = 1'b0;
    logic                     ready;
    logic [NL-1:0]            lane_valid = '0;
    logic [NL-1:0]            lane_we = '0;
    logic [NL-1:0][AW-1:0]    lane_addr = '0;
    logic [NL-1:0][DW-1:0]    lane_wdata = '0;
    logic [NL-1:0][DW-1:0]    lane_rdata;
    logic                     done;

    int tests = 0;
    int fails = 0;
    logic [DW-1:0] model [NWORDS];
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scr_arbiter i_scr_arbiter (
        .clk        (clk),
        .rst        (rst),
        .grp_start  (grp_start),
        .ready      (ready),
        .lane_valid (lane_valid),
        .lane_we    (lane_we),
        .lane_addr  (lane_addr),
        .lane_wdata (lane_wdata),
        .lane_rdata (lane_rdata),
        .done       (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic int exp_passes(input logic [NL-1:0] v, input logic [NL-1:0][AW-1:0] a);
        int cnt [NB];
        int mx = 0;
        for (int b = 0; b < NB; b++) cnt[b] = 0;
        for (int l = 0; l < NL; l++) begin
            if (v[l]) begin
                bit first = 1'b1;
                for (int j = 0; j < l; j++) begin
                    if (v[j] && a[j] == a[l]) first = 1'b0;
                end
                if (first) cnt[a[l] % NB]++;
            end
        end
        for (int b = 0; b < NB; b++) if (cnt[b] > mx) mx = cnt[b];
        return (mx == 0) ? 1 : mx;
    endfunction

    // Runs one group, checks pass count, read data, done/ready behaviour, updates model.
    task automatic run_group(input logic [NL-1:0] v, input logic [NL-1:0] w,
                             input logic [NL-1:0][AW-1:0] a, input logic [NL-1:0][DW-1:0] d,
                             input string req, input bit poke);
        logic [NL-1:0][DW-1:0] exp_rd;
        int passes;
        int cyc;
        bit seen;
        passes = exp_passes(v, a);
        for (int l = 0; l < NL; l++) exp_rd[l] = model[a[l]];
        @(negedge clk);
        chk(ready === 1'b1, "R7", "ready before offer", {31'd0, ready}, 32'd1);
        lane_valid = v; lane_we = w; lane_addr = a; lane_wdata = d;
        grp_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        grp_start = 1'b0;
        chk(ready === 1'b0, "R7", "ready low after accept", {31'd0, ready}, 32'd0);
        if (poke) begin
            // Ignored offer while busy: would overwrite word 0 if taken.
            grp_start = 1'b1;
            lane_valid = '1; lane_we = '1; lane_addr = '0;
            for (int l = 0; l < NL; l++) lane_wdata[l] = 32'hDEAD_0000 + l;
        end
        cyc = 0;
        seen = 1'b0;
        while (!seen && cyc < 40) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            grp_start = 1'b0;
            if (done === 1'b1) seen = 1'b1;
            else chk(ready === 1'b0, "R7", "ready low while busy", {31'd0, ready}, 32'd0);
        end
        chk(seen, req, "done seen (watchdog)", cyc, passes);
        chk(cyc == passes, req, "pass count", cyc, passes);
        chk(ready === 1'b1, "R8", "ready with done", {31'd0, ready}, 32'd1);
        for (int l = 0; l < NL; l++) begin
            if (v[l] && !w[l]) begin
                chk(lane_rdata[l] === exp_rd[l], req, $sformatf("lane %0d rdata", l),
                    lane_rdata[l], exp_rd[l]);
            end
        end
        for (int l = 0; l < NL; l++) begin
            if (v[l] && w[l]) model[a[l]] = d[l];
        end
        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0, "R8", "done one cycle only", {31'd0, done}, 32'd0);
        for (int l = 0; l < NL; l++) begin
            if (v[l] && !w[l]) begin
                chk(lane_rdata[l] === exp_rd[l], "R8", $sformatf("lane %0d rdata held", l),
                    lane_rdata[l], exp_rd[l]);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [NL-1:0][AW-1:0] a;
        logic [NL-1:0][DW-1:0] d;
        for (int i = 0; i < NWORDS; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        chk(ready === 1'b1, "R10", "ready after reset", {31'd0, ready}, 32'd1);
        chk(done === 1'b0, "R10", "done after reset", {31'd0, done}, 32'd0);
        for (int l = 0; l < NL; l++)
            chk(lane_rdata[l] === '0, "R10", "rdata after reset", lane_rdata[l], 32'd0);
        for (int l = 0; l < NL; l++) a[l] = AW'(l * 17);
        d = '0;
        run_group('1, '0, a, d, "R10", 1'b0);

        // R1/R2: fill every word with stride-1 write groups
        for (int g = 0; g < NWORDS / NL; g++) begin
            for (int l = 0; l < NL; l++) begin
                a[l] = AW'(g * NL + l);
                d[l] = 32'h1000_0000 + (32'(g * NL + l) * 32'h0101_0101);
            end
            run_group('1, '1, a, d, "R1", 1'b0);
        end

        // R2/R4: strided reads, strides 1..16, two bases
        for (int s = 1; s <= 16; s++) begin
            for (int base = 0; base < 2; base++) begin
                for (int l = 0; l < NL; l++) a[l] = AW'(base * 5 + s * l);
                run_group('1, '0, a, d, (s % 2 == 1) ? "R2" : "R4", 1'b0);
            end
        end
        chk(exp_passes('1, a) == 16, "R4", "stride 16 model", exp_passes('1, a), 16);

        // R3: broadcast read
        for (int l = 0; l < NL; l++) a[l] = 8'd77;
        run_group('1, '0, a, d, "R3", 1'b0);

        // R4: merged duplicates, four distinct rows in bank 0
        for (int l = 0; l < NL; l++) a[l] = AW'((l / 4) * 16);
        run_group('1, '0, a, d, "R4", 1'b0);

        // R5: all lanes write one word, then read back
        for (int l = 0; l < NL; l++) begin
            a[l] = 8'd5;
            d[l] = 32'hC0DE_0000 + l;
        end
        run_group('1, '1, a, d, "R5", 1'b0);
        chk(model[5] == 32'hC0DE_000F, "R5", "model winner", model[5], 32'hC0DE_000F);
        run_group('1, '0, a, d, "R5", 1'b0);

        // R6: reads and a write of the same word in one group
        for (int l = 0; l < NL; l++) begin
            a[l] = AW'(l + 32);
            d[l] = 32'h0;
        end
        a[0] = 8'd9; a[1] = 8'd9; a[3] = 8'd9; d[3] = 32'hFACE_0009;
        run_group('1, 16'h0008, a, d, "R6", 1'b0);
        run_group('1, '0, a, d, "R6", 1'b0);

        // R9: invalid lanes carry conflicting writes that must not land
        for (int l = 0; l < NL; l++) begin
            a[l] = (l < 8) ? AW'(l) : AW'(16 * l + (l - 8));
            d[l] = 32'hBAD0_0000 + l;
        end
        run_group(16'h00FF, 16'hFF00, a, d, "R9", 1'b0);
        run_group('1, '0, a, d, "R9", 1'b0);
        run_group('0, '1, a, d, "R9", 1'b0);
        run_group('1, '0, a, d, "R9", 1'b0);

        // R7: offer while busy is ignored (stride-8 group, then read word 0)
        for (int l = 0; l < NL; l++) a[l] = AW'(8 * l);
        run_group('1, '0, a, d, "R7", 1'b1);
        for (int l = 0; l < NL; l++) a[l] = 8'd0;
        run_group('1, '0, a, d, "R7", 1'b0);

        // R4/R5/R6: pseudo-random mixed groups over shrinking address ranges
        for (int g = 0; g < 300; g++) begin
            logic [NL-1:0] v;
            logic [NL-1:0] w;
            logic [7:0] mask;
            mask = (g % 3 == 0) ? 8'hFF : ((g % 3 == 1) ? 8'h3F : 8'h13);
            v = 16'(next_rand()) | 16'h0001;
            w = 16'(next_rand());
            for (int l = 0; l < NL; l++) begin
                a[l] = 8'(next_rand()) & mask;
                d[l] = next_rand();
            end
            run_group(v, w, a, d, "R4", 1'b0);
        end

        // R1: final read-back of all words
        for (int g = 0; g < NWORDS / NL; g++) begin
            for (int l = 0; l < NL; l++) a[l] = AW'(g * NL + l);
            run_group('1, '0, a, d, "R1", 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule